// File: doc/BRIEF.md
# ADC Result Byte Formatter with Read-Order Lock

This block sits between a 10-bit converter core and a byte-wide processor bus. Each time the core pulses its done strobe, the block takes the result and stores it as a high byte and a low byte. A two-bit mode input picks the byte layout. Left-justified mode places the upper eight result bits in the high byte. Signed left-justified mode does the same but inverts the top result bit. Truncation mode keeps only the upper eight bits, places them in the low byte and returns zero from the high byte.

Software reads the high byte first and the low byte second. Reading the high byte freezes both stored bytes until the low byte is read, so the pair always comes from one conversion. Results that complete while the pair is frozen are thrown away, and a sticky flag records that this happened. Truncation mode uses only one byte, so it never freezes. Switching the mode releases any freeze, and the new layout applies from the next stored result.

Top module: `adc_result_fmt`

## Requirements
- R1: With mode 2'b00 (and 2'b11), a stored result r reads back as high byte r[9:2] and low byte {r[1:0], 6'b0}.
- R2: With mode 2'b01, the high byte is {~r[9], r[8:2]} and the low byte is {r[1:0], 6'b0}.
- R3: With mode 2'b10, the high byte reads 8'h00 and the low byte reads r[9:2].
- R4: A read of the high byte at address 8'h3D in mode 2'b00, 2'b01 or 2'b11 sets the lock. A read of the low byte at address 8'h3E clears it.
- R5: While the lock is held, completed results are discarded and both bytes keep their values. This includes a result that completes in the same cycle as the high-byte read.
- R6: `result_lost` goes high in the cycle after a result is discarded. It stays high until a low-byte read and is not cleared by that read in a cycle that discards another result.
- R7: A low-byte read with no prior high-byte read does not set the lock, so the next result is stored.
- R8: In mode 2'b10, a high-byte read does not set the lock, and every completed result is stored.
- R9: A change of `fmt_mode` clears the lock, and the next stored result uses the new layout.
- R10: A cycle with `bus_wr` high is never a read. `bus_rdata` is zero in that cycle, and the cycle neither sets the lock nor alters the stored bytes.
- R11: Reset clears the lock and `result_lost` but leaves the stored bytes unchanged.
- R12: `bus_rdata` is zero unless `bus_rd` is high with `bus_wr` low and the address is 8'h3D or 8'h3E. A read returns the stored byte in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| conv_done | input | 1 | One-cycle pulse marking a completed conversion |
| conv_result | input | 10 | Conversion result, valid with `conv_done` |
| fmt_mode | input | 2 | Byte layout: 00/11 left, 01 signed left, 10 truncated |
| bus_addr | input | 8 | Bus address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe; data registers ignore writes |
| bus_rdata | output | 8 | Read data, combinational from address and strobes |
| result_lost | output | 1 | Sticky flag: a result was discarded under the lock |

## Verification
The bound checker watches the lock every cycle. It checks that frozen bytes hold while results arrive, that a discard raises the lost flag, that truncation mode and a mode change leave the lock clear, that a low-byte read releases the lock, and that the lock rises only after a high-byte read. The bench's scenarios cover the rest: the exact byte layouts in each mode, the same-cycle collision between a high-byte read and a done strobe, ignored writes, and byte contents that survive reset.

// File: rtl/adc_fmt_pkg.sv
package adc_fmt_pkg;
  typedef enum logic [1:0] {
    FMT_LEFT     = 2'b00,
    FMT_LEFT_SGN = 2'b01,
    FMT_TRUNC8   = 2'b10,
    FMT_LEFT_ALT = 2'b11
  } fmt_e;
endpackage

// File: rtl/adc_rst_sync.sv
module adc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_one
      assign sync_d = 1'b1;
    end else begin : g_chain
      assign sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/adc_fmt_encode.sv
module adc_fmt_encode
  import adc_fmt_pkg::*;
#(
  parameter int RES_W  = 10,
  parameter int DATA_W = 8
) (
  input  logic [RES_W-1:0]  res,
  input  fmt_e              mode,
  output logic [DATA_W-1:0] hi_byte,
  output logic [DATA_W-1:0] lo_byte
);
  localparam int LOW_BITS = RES_W - DATA_W;

  always_comb begin
    hi_byte = res[RES_W-1 -: DATA_W];
    lo_byte = '0;
    lo_byte[DATA_W-1 -: LOW_BITS] = res[LOW_BITS-1:0];
    case (mode)
      FMT_LEFT_SGN: hi_byte[DATA_W-1] = ~res[RES_W-1];
      FMT_TRUNC8: begin
        hi_byte = '0;
        lo_byte = res[RES_W-1 -: DATA_W];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/adc_rd_decode.sv
module adc_rd_decode #(
  parameter int                ADDR_W  = 8,
  parameter int                DATA_W  = 8,
  parameter logic [ADDR_W-1:0] HI_ADDR = 8'h3D,
  parameter logic [ADDR_W-1:0] LO_ADDR = 8'h3E
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] hi_q,
  input  logic [DATA_W-1:0] lo_q,
  output logic              rd_hi,
  output logic              rd_lo,
  output logic [DATA_W-1:0] rdata
);
  logic rd_ok;

  always_comb begin
    rd_ok = bus_rd & ~bus_wr;
    rd_hi = rd_ok & (bus_addr == HI_ADDR);
    rd_lo = rd_ok & (bus_addr == LO_ADDR);
    rdata = '0;
    if (rd_hi)      rdata = hi_q;
    else if (rd_lo) rdata = lo_q;
  end
endmodule

// File: rtl/adc_rd_lock.sv
module adc_rd_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic conv_done,
  input  logic rd_hi,
  input  logic rd_lo,
  input  logic trunc,
  input  logic mode_chg,
  output logic cap_en,
  output logic lock_q,
  output logic lost_q
);
  logic lock_d, lost_d, block;

  always_comb begin
    block  = lock_q | (rd_hi & ~trunc);
    cap_en = conv_done & ~block;

    lost_d = lost_q;
    if (conv_done & block) lost_d = 1'b1;
    else if (rd_lo)        lost_d = 1'b0;

    lock_d = lock_q;
    if (mode_chg)             lock_d = 1'b0;
    else if (rd_lo)           lock_d = 1'b0;
    else if (rd_hi & ~trunc)  lock_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      lost_q <= 1'b0;
    end else begin
      lock_q <= lock_d;
      lost_q <= lost_d;
    end
  end
endmodule

// File: rtl/adc_result_fmt.sv
module adc_result_fmt
  import adc_fmt_pkg::*;
#(
  parameter int                RES_W       = 10,
  parameter int                DATA_W      = 8,
  parameter int                ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] HI_ADDR     = 8'h3D,
  parameter logic [ADDR_W-1:0] LO_ADDR     = 8'h3E,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_result,
  input  logic [1:0]        fmt_mode,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              result_lost
);
  logic              rst_n_s;
  fmt_e              mode_cur, mode_q;
  logic              mode_chg, trunc;
  logic [DATA_W-1:0] hi_fmt, lo_fmt, hi_q, lo_q;
  logic              rd_hi, rd_lo, cap_en, lock_q, lost_q;

  adc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  always_comb begin
    mode_cur = fmt_e'(fmt_mode);
    mode_chg = (mode_cur != mode_q);
    trunc    = (mode_cur == FMT_TRUNC8);
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) mode_q <= FMT_LEFT;
    else          mode_q <= mode_cur;
  end

  adc_fmt_encode #(.RES_W(RES_W), .DATA_W(DATA_W)) u_enc (
    .res(conv_result), .mode(mode_cur), .hi_byte(hi_fmt), .lo_byte(lo_fmt)
  );

  adc_rd_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .HI_ADDR(HI_ADDR), .LO_ADDR(LO_ADDR)
  ) u_dec (
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .hi_q(hi_q), .lo_q(lo_q), .rd_hi(rd_hi), .rd_lo(rd_lo), .rdata(bus_rdata)
  );

  adc_rd_lock u_lock (
    .clk(clk), .rst_n(rst_n_s), .conv_done(conv_done), .rd_hi(rd_hi),
    .rd_lo(rd_lo), .trunc(trunc), .mode_chg(mode_chg),
    .cap_en(cap_en), .lock_q(lock_q), .lost_q(lost_q)
  );

  // Data bytes carry no reset: their contents survive a reset.
  always_ff @(posedge clk) begin
    if (cap_en) begin
      hi_q <= hi_fmt;
      lo_q <= lo_fmt;
    end
  end

  assign result_lost = lost_q;
endmodule

// File: rtl/adc_result_fmt_chk.sv
module adc_result_fmt_chk #(
  parameter int                ADDR_W  = 8,
  parameter int                DATA_W  = 8,
  parameter logic [ADDR_W-1:0] HI_ADDR = 8'h3D,
  parameter logic [ADDR_W-1:0] LO_ADDR = 8'h3E
) (
  input logic              clk,
  input logic              rst_n_s,
  input logic              conv_done,
  input logic [1:0]        fmt_mode,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              mode_chg,
  input logic              cap_en,
  input logic              lock_q,
  input logic              lost_q,
  input logic [DATA_W-1:0] hi_q,
  input logic [DATA_W-1:0] lo_q
);
  assert_locked_hold_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (conv_done && lock_q) |=> ($stable(hi_q) && $stable(lo_q)));

  assert_lost_on_drop_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (conv_done && lock_q) |=> lost_q);

  assert_trunc_hi_zero_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cap_en && fmt_mode == 2'b10) |=> (hi_q == '0));

  assert_trunc_no_lock_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (fmt_mode == 2'b10) |=> !lock_q);

  assert_mode_chg_unlock_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    mode_chg |=> !lock_q);

  assert_lo_read_unlock_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (bus_rd && !bus_wr && bus_addr == LO_ADDR) |=> !lock_q);

  assert_lock_from_hi_read_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(lock_q) |-> $past(bus_rd && !bus_wr && bus_addr == HI_ADDR));

  assert_idle_rdata_zero_R12: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!bus_rd || bus_wr) |-> (bus_rdata == '0));
endmodule

bind adc_result_fmt adc_result_fmt_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .HI_ADDR(HI_ADDR), .LO_ADDR(LO_ADDR)
) u_chk (
  .clk(clk), .rst_n_s(rst_n_s), .conv_done(conv_done), .fmt_mode(fmt_mode),
  .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(bus_rdata),
  .mode_chg(mode_chg), .cap_en(cap_en), .lock_q(lock_q), .lost_q(lost_q),
  .hi_q(hi_q), .lo_q(lo_q)
);

// File: tb/tb_adc_result_fmt.sv
module tb_adc_result_fmt;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       conv_done;
  logic [9:0] conv_result;
  logic [1:0] fmt_mode;
  logic [7:0] bus_addr;
  logic       bus_rd, bus_wr;
  logic [7:0] bus_rdata;
  logic       result_lost;

  int n_run = 0;
  int n_fail = 0;

  // reference model state
  logic [7:0] m_hi, m_lo;
  bit         m_valid = 1'b0;
  bit         m_lock, m_lost;
  logic [1:0] m_mode;

  always #5 clk = ~clk;

  adc_result_fmt dut (
    .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_result(conv_result),
    .fmt_mode(fmt_mode), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_rdata(bus_rdata), .result_lost(result_lost)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // One bus cycle: drive at negedge, compare against model, advance model at posedge.
  task automatic cyc(input bit cd, input logic [9:0] res, input logic [1:0] md,
                     input bit rd, input bit wr, input logic [7:0] a,
                     input string tag, output logic [7:0] got, output logic lg);
    bit rh, rl, blk;
    logic [7:0] exp, fh, fl;
    @(negedge clk);
    conv_done = cd; conv_result = res; fmt_mode = md;
    bus_rd = rd; bus_wr = wr; bus_addr = a;
    #1;
    got = bus_rdata;
    lg  = result_lost;
    rh  = rd && !wr && (a == 8'h3D);
    rl  = rd && !wr && (a == 8'h3E);
    exp = rh ? m_hi : (rl ? m_lo : 8'h00);
    if (m_valid || !(rh || rl)) chk({tag, " model rdata"}, got, exp);
    chk({tag, " model lost"}, {7'b0, lg}, {7'b0, m_lost});
    @(posedge clk);
    fh = res[9:2];
    fl = {res[1:0], 6'b0};
    if (md == 2'b01) fh = fh ^ 8'h80;
    if (md == 2'b10) begin fl = res[9:2]; fh = 8'h00; end
    blk = m_lock || (rh && md != 2'b10);
    if (cd && !blk) begin m_hi = fh; m_lo = fl; m_valid = 1'b1; end
    if (cd && blk) m_lost = 1'b1;
    else if (rl)   m_lost = 1'b0;
    if (md != m_mode)           m_lock = 1'b0;
    else if (rl)                m_lock = 1'b0;
    else if (rh && md != 2'b10) m_lock = 1'b1;
    m_mode = md;
  endtask

  task automatic do_reset();
    @(negedge clk);
    conv_done = 1'b0; conv_result = '0; fmt_mode = 2'b00;
    bus_rd = 1'b0; bus_wr = 1'b0; bus_addr = '0;
    rst_n = 1'b0;
    m_lock = 1'b0; m_lost = 1'b0; m_mode = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] g;
    logic       l;
    do_reset();

    // R11 / R12: reset state and idle bus
    cyc(0, 10'h0, 2'b00, 0, 0, 8'h3D, "R12", g, l);
    chk("R11 lost after reset", {7'b0, l}, 8'h00);
    chk("R12 idle rdata", g, 8'h00);

    // R1 left justified
    cyc(1, 10'h2C5, 2'b00, 0, 0, 8'h00, "R1", g, l);
    cyc(0, 10'h0, 2'b00, 1, 0, 8'h3D, "R1", g, l); chk("R1 hi", g, 8'hB1);
    cyc(0, 10'h0, 2'b00, 1, 0, 8'h3E, "R1", g, l); chk("R1 lo", g, 8'h40);

    // R2 signed left justified
    cyc(0, 10'h0, 2'b01, 0, 0, 8'h00, "R2", g, l);
    cyc(1, 10'h2C5, 2'b01, 0, 0, 8'h00, "R2", g, l);
    cyc(0, 10'h0, 2'b01, 1, 0, 8'h3D, "R2", g, l); chk("R2 hi", g, 8'h31);
    cyc(0, 10'h0, 2'b01, 1, 0, 8'h3E, "R2", g, l); chk("R2 lo", g, 8'h40);

    // R3 truncation
    cyc(0, 10'h0, 2'b10, 0, 0, 8'h00, "R3", g, l);
    cyc(1, 10'h3FF, 2'b10, 0, 0, 8'h00, "R3", g, l);
    cyc(0, 10'h0, 2'b10, 1, 0, 8'h3D, "R3", g, l); chk("R3 hi", g, 8'h00);
    cyc(0, 10'h0, 2'b10, 1, 0, 8'h3E, "R3", g, l); chk("R3 lo", g, 8'hFF);

    // R4 / R5 / R6 interlock and discard
    cyc(0, 10'h0, 2'b00, 0, 0, 8'h00, "R4", g, l);
    cyc(1, 10'h155, 2'b00, 0, 0, 8'h00, "R4", g, l);
    cyc(0, 10'h0, 2'b00, 1, 0, 8'h3D, "R4", g, l); chk("R4 hi", g, 8'h55);
    cyc(1, 10'h3FF, 2'b00, 0, 0, 8'h00, "R5", g, l);
    cyc(0, 10'h0, 2'b00, 0, 0, 8'h00, "R6", g, l); chk("R6 lost set", {7'b0, l}, 8'h01);
    cyc(0, 10'h0, 2'b00, 1, 0, 8'h3E, "R5", g, l); chk("R5 lo held", g, 8'h40);
    cyc(0, 10'h0, 2'b00, 0, 0, 8'h00, "R6", g, l); chk("R6 lost cleared", {7'b0, l}, 8'h00);
    cyc(0, 10'h0, 2'b00, 1, 0, 8'h3D, "R5", g, l); chk("R5 hi kept", g, 8'h55);
    cyc(0, 10'h0, 2'b00, 1, 0, 8'h3E, "R4", g, l);

    // R7 low read without high read
    cyc(0, 10'h0, 2'b00, 1, 0, 8'h3E, "R7", g, l);
    cyc(1, 10'h0AA, 2'b00, 0, 0, 8'h00, "R7", g, l);
    cyc(0, 10'h0, 2'b00, 1, 0, 8'h3D, "R7", g, l); chk("R7 hi", g, 8'h2A);
    cyc(0, 10'h0, 2'b00, 1, 0, 8'h3E, "R7", g, l); chk("R7 lo", g, 8'h80);
    chk("R7 no loss", {7'b0, l}, 8'h00);

    // R8 truncation has no interlock
    cyc(0, 10'h0, 2'b10, 0, 0, 8'h00, "R8", g, l);
    cyc(0, 10'h0, 2'b10, 1, 0, 8'h3D, "R8", g, l);
    cyc(1, 10'h200, 2'b10, 0, 0, 8'h00, "R8", g, l);
    cyc(0, 10'h0, 2'b10, 1, 0, 8'h3E, "R8", g, l); chk("R8 lo", g, 8'h80);
    chk("R8 no loss", {7'b0, l}, 8'h00);

    // R9 mode change releases lock
    cyc(0, 10'h0, 2'b00, 0, 0, 8'h00, "R9", g, l);
    cyc(1, 10'h2C5, 2'b00, 0, 0, 8'h00, "R9", g, l);
    cyc(0, 10'h0, 2'b00, 1, 0, 8'h3D, "R9", g, l);
    cyc(0, 10'h0, 2'b01, 0, 0, 8'h00, "R9", g, l);
    cyc(1, 10'h2C5, 2'b01, 0, 0, 8'h00, "R9", g, l);
    cyc(0, 10'h0, 2'b01, 1, 0, 8'h3D, "R9", g, l); chk("R9 new format hi", g, 8'h31);
    cyc(0, 10'h0, 2'b01, 1, 0, 8'h3E, "R9", g, l); chk("R9 lo", g, 8'h40);

    // R10 writes have no effect
    cyc(0, 10'h0, 2'b01, 0, 1, 8'h3D, "R10", g, l); chk("R10 write rdata", g, 8'h00);
    cyc(1, 10'h0AA, 2'b01, 0, 0, 8'h00, "R10", g, l);
    cyc(0, 10'h0, 2'b01, 1, 1, 8'h3D, "R10", g, l); chk("R10 rd+wr rdata", g, 8'h00);
    cyc(1, 10'h3FF, 2'b01, 0, 0, 8'h00, "R10", g, l);
    cyc(0, 10'h0, 2'b01, 1, 0, 8'h3D, "R10", g, l); chk("R10 hi", g, 8'h7F);
    cyc(0, 10'h0, 2'b01, 1, 0, 8'h3E, "R10", g, l); chk("R10 lo", g, 8'hC0);

    // R5 collision: high read and done in the same cycle
    cyc(1, 10'h000, 2'b01, 1, 0, 8'h3D, "R5", g, l); chk("R5 collide hi old", g, 8'h7F);
    cyc(0, 10'h0, 2'b01, 0, 0, 8'h00, "R6", g, l); chk("R6 collide lost", {7'b0, l}, 8'h01);
    cyc(0, 10'h0, 2'b01, 1, 0, 8'h3E, "R5", g, l); chk("R5 collide lo", g, 8'hC0);

    // R12 other addresses
    cyc(0, 10'h0, 2'b01, 1, 0, 8'h3C, "R12", g, l); chk("R12 addr 3C", g, 8'h00);
    cyc(0, 10'h0, 2'b01, 1, 0, 8'h3F, "R12", g, l); chk("R12 addr 3F", g, 8'h00);

    // R11 reset clears lock and flag, keeps bytes
    cyc(0, 10'h0, 2'b01, 1, 0, 8'h3D, "R11", g, l);
    cyc(1, 10'h155, 2'b01, 0, 0, 8'h00, "R11", g, l);
    do_reset();
    cyc(0, 10'h0, 2'b00, 0, 0, 8'h00, "R11", g, l); chk("R11 lost cleared", {7'b0, l}, 8'h00);
    cyc(1, 10'h155, 2'b00, 0, 0, 8'h00, "R11", g, l);
    cyc(0, 10'h0, 2'b00, 1, 0, 8'h3D, "R11", g, l); chk("R11 unlocked capture", g, 8'h55);
    cyc(0, 10'h0, 2'b00, 1, 0, 8'h3E, "R11", g, l); chk("R11 lo", g, 8'h40);
    do_reset();
    cyc(0, 10'h0, 2'b00, 1, 0, 8'h3D, "R11", g, l); chk("R11 hi retained", g, 8'h55);
    cyc(0, 10'h0, 2'b00, 1, 0, 8'h3E, "R11", g, l); chk("R11 lo retained", g, 8'h40);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule